// File: doc/BRIEF.md
# Quarter-Period IQ Sample Splitter

This block sits directly behind a 12-bit converter. The converter samples an intermediate-frequency carrier at a rate where each new sample advances the carrier phase by a quarter period. The incoming stream therefore repeats a four-step cycle. The first step carries the in-phase part and the second the quadrature part. The third and fourth steps carry those same two parts with the sign inverted. The splitter tracks the step with a two-bit position counter. It routes each sample to either an in-phase output or a quadrature output, and undoes the inversion on steps two and three.

Each output channel is registered and raises its own valid strobe. When no new sample arrives, the channel holds its last value. A half-rate enable pulses once for every completed in-phase/quadrature pair, and it times the two decimation filters downstream. A slower synchronisation input is sampled in the system clock domain. Each rising edge of that input forces the current sample to step 0, so the step assignment is known after power-up.

Top module: `iq_demux`

## Requirements
- R1: While `rst_n` is low, `i_out`, `q_out`, `i_vld`, `q_vld` and `half_en` are all zero.
- R2: The step counter starts at 0 on the first clock edge after reset release and advances by one, modulo 4, on every edge.
- R3: Samples at step 0 and step 2 update `i_out`. Samples at step 1 and step 3 update `q_out`. The channel not updated keeps its previous value.
- R4: Samples at step 2 and step 3 are negated in two's complement before they are stored. Samples at step 0 and step 1 pass unchanged.
- R5: Negating the most negative code (-2048, 12'h800) yields +2047 (12'h7FF) and does not wrap.
- R6: A sample presented before clock edge k appears on its output right after edge k (one cycle of latency).
- R7: `i_vld` is high for exactly the cycle after a step-0 or step-2 sample. `q_vld` is high for exactly the cycle after a step-1 or step-3 sample. The two are never high together.
- R8: `half_en` is high for the cycle after each step-1 or step-3 sample. In an uninterrupted run this gives one pulse every two clocks, each pulse marking a completed pair.
- R9: A rising edge of `sync_in` is a cycle where `sync_in` is high and was low at the previous edge, with reset counting as low. On such an edge the sample of that cycle is step 0 and counting resumes from there. Holding `sync_in` high causes no further realignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one converter sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_in | input | 12 | Signed converter sample |
| sync_in | input | 1 | Synchronisation level; rising edge realigns to step 0 |
| i_out | output | 12 | Signed in-phase sample, sign restored |
| i_vld | output | 1 | In-phase output updated this cycle |
| q_out | output | 12 | Signed quadrature sample, sign restored |
| q_vld | output | 1 | Quadrature output updated this cycle |
| half_en | output | 1 | Half-rate enable, one pulse per completed pair |

## Verification
Random samples in a free-running step sequence check routing and sign restoration together. A pure pass-through would fail this, and so would swapping the two channels or negating the wrong steps. Directed runs feed -2048, +2047 and zero on every step. These separate saturation from wrap-around and confirm that zero stays zero. Sync edges are placed at every step offset and are also held high for several cycles. This shows that only a rising edge realigns. A mid-run reset shows that counting restarts at step 0.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;
  localparam int unsigned STEPS   = 4;
  localparam int unsigned STEP_W  = $clog2(STEPS);
  localparam logic [STEP_W-1:0] STEP_I  = 2'd0;
  localparam logic [STEP_W-1:0] STEP_Q  = 2'd1;
  localparam logic [STEP_W-1:0] STEP_NI = 2'd2;
  localparam logic [STEP_W-1:0] STEP_NQ = 2'd3;
  localparam int unsigned CH_I = 0;
  localparam int unsigned CH_Q = 1;
endpackage

// File: rtl/iq_phase_seq.sv
module iq_phase_seq
  import iq_demux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  output logic [STEP_W-1:0] step,
  output logic              realign
);
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic              sync_q, sync_d;

  always_comb begin
    realign = sync_in & ~sync_q;
    step    = realign ? STEP_I : cnt_q;
    cnt_d   = step + 1'b1;
    sync_d  = sync_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  p_step_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !realign |=> cnt_q == STEP_W'($past(cnt_q) + 1'b1));
  p_realign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> cnt_q == STEP_Q);
endmodule

// File: rtl/iq_sign_fix.sv
module iq_sign_fix #(
  parameter int unsigned W        = 12,
  parameter bit          SATURATE = 1'b1
) (
  input  logic [W-1:0] din,
  input  logic         negate,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] neg_val;

  generate
    if (SATURATE) begin : g_sat
      always_comb neg_val = (din == MOST_NEG) ? MOST_POS : (~din + 1'b1);
    end else begin : g_wrap
      always_comb neg_val = ~din + 1'b1;
    end
  endgenerate

  always_comb dout = negate ? neg_val : din;
endmodule

// File: rtl/iq_out_stage.sv
module iq_out_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] data,
  output logic         vld
);
  logic [W-1:0] data_d;
  logic         vld_d;

  always_comb begin
    data_d = load ? din : data;
    vld_d  = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      vld  <= 1'b0;
    end else begin
      data <= data_d;
      vld  <= vld_d;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(data));
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> data == $past(din));
  p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> vld);
endmodule

// File: rtl/iq_demux.sv
module iq_demux
  import iq_demux_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter bit          SATURATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp_in,
  input  logic         sync_in,
  output logic [W-1:0] i_out,
  output logic         i_vld,
  output logic [W-1:0] q_out,
  output logic         q_vld,
  output logic         half_en
);
  localparam int unsigned NCH = 2;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [STEP_W-1:0] step;
  logic              realign;
  logic [W-1:0]      fixed;
  logic              half_d;
  logic [W-1:0]      ch_data [NCH];
  logic              ch_vld  [NCH];

  iq_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .step    (step),
    .realign (realign)
  );

  iq_sign_fix #(.W(W), .SATURATE(SATURATE)) u_fix (
    .din    (smp_in),
    .negate (step[1]),
    .dout   (fixed)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic load;
      always_comb load = (step[0] == ch[0]);
      iq_out_stage #(.W(W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (fixed),
        .data  (ch_data[ch]),
        .vld   (ch_vld[ch])
      );
    end
  endgenerate

  always_comb begin
    i_out  = ch_data[CH_I];
    i_vld  = ch_vld[CH_I];
    q_out  = ch_data[CH_Q];
    q_vld  = ch_vld[CH_Q];
    half_d = step[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_en <= 1'b0;
    else        half_en <= half_d;
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i_vld, q_vld}));
  p_sync_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> i_vld && i_out == $past(smp_in));
  p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_NI && smp_in == MOST_NEG) |=> i_out == MOST_POS);
  p_neg_i_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_NI && smp_in != MOST_NEG) |=> W'(i_out + $past(smp_in)) == '0);
  p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_Q || step == STEP_NQ) |=> half_en && q_vld);
endmodule

// File: tb/tb_iq_demux.sv
module tb_iq_demux;
  localparam int W = 12;
  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] smp_in;
  logic sync_in;
  logic [W-1:0] i_out, q_out;
  logic i_vld, q_vld, half_en;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  int m_pos; bit m_sync;
  logic [W-1:0] e_i, e_q; bit e_iv, e_qv, e_half;
  string e_tag;

  always #4 clk = ~clk;

  iq_demux dut (.clk(clk), .rst_n(rst_n), .smp_in(smp_in), .sync_in(sync_in),
                .i_out(i_out), .i_vld(i_vld), .q_out(q_out), .q_vld(q_vld),
                .half_en(half_en));

  function automatic logic [W-1:0] neg_sat(logic [W-1:0] v);
    if (v == 12'h800) return 12'h7FF;
    return -v;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pos = 0; m_sync = 0;
    e_i = '0; e_q = '0; e_iv = 0; e_qv = 0; e_half = 0; e_tag = "R1";
  endtask

  // Drive at negedge, predict the state after the next posedge (R6: one cycle).
  task automatic drive(logic [W-1:0] s, bit sy);
    bit rise; int p; logic [W-1:0] v;
    smp_in = s; sync_in = sy;
    rise = sy && !m_sync;
    p = rise ? 0 : m_pos;
    m_pos = (p + 1) % 4;
    m_sync = sy;
    v = (p >= 2) ? neg_sat(s) : s;
    if (p % 2 == 0) begin e_i = v; e_iv = 1; e_qv = 0; end
    else            begin e_q = v; e_iv = 0; e_qv = 1; end
    e_half = (p % 2 == 1);
    if (rise) e_tag = "R9 R2 R6";
    else if (s == 12'h800 && p >= 2) e_tag = "R5 R6";
    else if (p >= 2) e_tag = "R4 R3 R6";
    else e_tag = "R3 R2 R6";
  endtask

  task automatic step_check(logic [W-1:0] s, bit sy);
    drive(s, sy);
    @(negedge clk);
    chk({e_tag, " i_out"}, i_out, e_i);
    chk({e_tag, " q_out"}, q_out, e_q);
    chk("R7 i_vld", W'(i_vld), W'(e_iv));
    chk("R7 q_vld", W'(q_vld), W'(e_qv));
    chk("R8 half_en", W'(half_en), W'(e_half));
  endtask

  task automatic check_reset_state();
    chk("R1 i_out", i_out, '0);
    chk("R1 q_out", q_out, '0);
    chk("R1 strobes", W'({i_vld, q_vld, half_en}), '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; smp_in = '0; sync_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1;

    // R2 R3 R4: random samples, free-running steps
    for (int n = 0; n < 400; n++) step_check(W'($urandom), 1'b0);

    // R5: extreme codes on every step
    for (int n = 0; n < 8; n++) step_check(12'h800, 1'b0);
    for (int n = 0; n < 8; n++) step_check(12'h7FF, 1'b0);
    for (int n = 0; n < 4; n++) step_check(12'h000, 1'b0);

    // R9: sync rises at each step offset, then held high
    for (int off = 0; off < 4; off++) begin
      for (int n = 0; n < off + 3; n++) step_check(W'($urandom), 1'b0);
      for (int n = 0; n < 6; n++) step_check(W'($urandom), 1'b1);
    end
    for (int n = 0; n < 2; n++) step_check(W'($urandom), 1'b0);

    // Random mix of samples and sync pulses
    for (int n = 0; n < 600; n++)
      step_check(($urandom % 8 == 0) ? 12'h800 : W'($urandom), ($urandom % 13) == 0);

    // R1 R2: mid-run reset, counting restarts at step 0
    rst_n = 0;
    #1;
    model_reset();
    check_reset_state();
    @(negedge clk);
    check_reset_state();
    rst_n = 1;
    for (int n = 0; n < 40; n++) step_check(W'($urandom), 1'b0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule